// File: doc/BRIEF.md
# Dual-Modulus Prescaler (Divide by 10/11)

This block divides a fast input clock by 10 or 11. Two mode pins choose the ratio. It is meant as the front stage of a pulse-swallow frequency synthesiser. In that arrangement a slower counter, clocked by this block's output, moves the mode pins to set the overall modulus.

The design has two stages. A three-flop shift counter steps through five or six states. A toggle flop flips each time that counter completes a pass and drives both output rails. The low half of the output always lasts five input clocks. The extra sixth state is inserted only in the high half, and only when the divide-by-11 ratio was chosen.

The mode pins are looked at on exactly one clock edge per output period: the edge on which the output rises. The length of the period is therefore fixed from the moment it begins. The mode pins may change, or glitch, at any other time without effect. A parameter builds a divide-by-5/6 variant that has no toggle stage. In that variant the output is taken directly from the shift counter.

Top module: `presc_dual_modulus`

## Requirements
- R1: With `TOGGLE_STAGE`=1 and both mode pins low at the sampling edge, the output period is 11 input clocks.
- R2: With `TOGGLE_STAGE`=1 and either mode pin high at the sampling edge, the output period is 10 input clocks.
- R3: In a divide-by-11 period, `q` is high for 6 clocks and then low for 5.
- R4: In a divide-by-10 period, `q` is high for 5 clocks and then low for 5.
- R5: The mode pins are sampled only on the clock edge at which `q` rises, and that sample sets the length of the period that begins there. Values on the mode pins at any other edge have no effect on that period.
- R6: `q_n` is the complement of `q` on every cycle.
- R7: `rst` is a synchronous, active-high reset. After any edge with `rst` high, `q` is 0 and `q_n` is 1. The first edge with `rst` low raises `q` and samples the mode pins for the first period.
- R8: With `TOGGLE_STAGE`=0 the block divides by 6 when both mode pins are low and by 5 otherwise. `q` rises on the sampling edge and stays high for 3 clocks (divide by 6) or 2 clocks (divide by 5), then stays low for 3 clocks. `q_n` is its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_a | input | 1 | Mode control; a high level selects the shorter modulus |
| mode_b | input | 1 | Mode control; a high level selects the shorter modulus |
| q | output | 1 | Divided output |
| q_n | output | 1 | Complement of `q` |

## Verification
The bench builds two copies of the block side by side, fed by the same pins: one with `TOGGLE_STAGE`=1 and one with `TOGGLE_STAGE`=0. The first copy covers the 6/5 and 5/5 waveforms, the sampling point on the rising edge, and mode changes in the middle of a period. The second copy covers the direct counter output of the 5/6 variant, where the same sampling edge also starts a period that is high for 3 or 2 clocks. Because both copies see the same mode pins, every random mode pattern, and the mid-run reset, is applied to both variants on the same cycles.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int SHIFT_BITS = 3;
  typedef logic [SHIFT_BITS-1:0] shift_t;
  // Last state of every pass; also the reset state, one edge before q rises.
  localparam shift_t SHIFT_LAST = shift_t'(3'b100);
endpackage

// File: rtl/presc_shift_ctr.sv
module presc_shift_ctr
  import presc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   skip,   // leave out the all-zero state on the next wrap
  output shift_t state
);
  logic   fb;
  logic   stray;
  shift_t nxt;

  // 010 is never reached in the main cycle; steer it straight to the last state.
  assign stray = ~state[2] & state[1] & ~state[0];
  assign fb    = (~state[2] | (skip & ~state[1])) & ~stray;
  assign nxt   = {state[1], state[0], fb};

  always_ff @(posedge clk) begin
    if (rst) state <= SHIFT_LAST;
    else     state <= nxt;
  end
endmodule

// File: rtl/presc_toggle.sv
module presc_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic q,
  output logic q_n
);
  // Two separate flops so each rail is driven by its own register.
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      q_n <= 1'b1;
    end else if (flip) begin
      q   <= ~q;
      q_n <= ~q_n;
    end
  end
endmodule

// File: rtl/presc_dual_modulus.sv
module presc_dual_modulus
  import presc_pkg::*;
#(
  parameter bit TOGGLE_STAGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_a,
  input  logic mode_b,
  output logic q,
  output logic q_n
);
  logic   want_long;
  logic   skip;
  shift_t state;

  assign want_long = ~(mode_a | mode_b);

  presc_shift_ctr u_ctr (
    .clk   (clk),
    .rst   (rst),
    .skip  (skip),
    .state (state)
  );

  generate
    if (TOGGLE_STAGE) begin : g_toggle
      logic at_last;
      assign at_last = (state == SHIFT_LAST);
      // While high, the next pass is the low half: always short.
      // While low, the next pass is the high half: length taken from the pins now.
      assign skip = q | ~want_long;
      presc_toggle u_tog (
        .clk  (clk),
        .rst  (rst),
        .flip (at_last),
        .q    (q),
        .q_n  (q_n)
      );
    end else begin : g_direct
      logic [1:0] unused_low_bits;
      assign unused_low_bits = state[1:0];
      assign skip = ~want_long;
      assign q    = ~state[2];
      assign q_n  = state[2];
    end
  endgenerate
endmodule

// File: rtl/presc_dual_modulus_chk.sv
module presc_dual_modulus_chk #(
  parameter bit TOGGLE_STAGE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic mode_a,
  input logic mode_b,
  input logic q,
  input logic q_n
);
  localparam logic [3:0] HI_LONG  = TOGGLE_STAGE ? 4'd6 : 4'd3;
  localparam logic [3:0] HI_SHORT = TOGGLE_STAGE ? 4'd5 : 4'd2;
  localparam logic [3:0] LO_LEN   = TOGGLE_STAGE ? 4'd5 : 4'd3;

  logic       prev_q, prev_long, commit_long, seen_rise, seen_fall;
  logic [3:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= 1'b0;
      prev_long   <= 1'b0;
      commit_long <= 1'b0;
      seen_rise   <= 1'b0;
      seen_fall   <= 1'b0;
      run         <= 4'd0;
    end else begin
      prev_q    <= q;
      prev_long <= ~(mode_a | mode_b);
      if (q != prev_q)     run <= 4'd1;
      else if (run != 4'hF) run <= run + 4'd1;
      if (q && !prev_q) begin
        commit_long <= prev_long;
        seen_rise   <= 1'b1;
      end
      if (!q && prev_q) seen_fall <= 1'b1;
    end
  end

  // R7: reset leaves the output low with its complement high
  assert_reset_out_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!q && q_n));

  // R5 with R3/R4/R8: high run matches the modulus sampled when q rose
  assert_high_len_R5: assert property (@(posedge clk) disable iff (rst)
    (!q && prev_q && seen_rise) |-> (run == (commit_long ? HI_LONG : HI_SHORT)));

  // R3/R4/R8: low run has a fixed length
  assert_low_len_R3: assert property (@(posedge clk) disable iff (rst)
    (q && !prev_q && seen_fall) |-> (run == LO_LEN));

  generate
    if (TOGGLE_STAGE) begin : g_comp
      // R6: the two separately registered rails stay complementary
      assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
        q_n == ~q);
    end
  endgenerate
endmodule

bind presc_dual_modulus presc_dual_modulus_chk #(.TOGGLE_STAGE(TOGGLE_STAGE)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mode_a (mode_a),
  .mode_b (mode_b),
  .q      (q),
  .q_n    (q_n)
);

// File: tb/test_presc_dual_modulus.sv
module test_presc_dual_modulus;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_a = 1'b0;
  logic mode_b = 1'b0;
  logic q0, qn0, q1, qn1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  presc_dual_modulus #(.TOGGLE_STAGE(1'b1)) i_presc_dual_modulus (
    .clk(clk), .rst(rst), .mode_a(mode_a), .mode_b(mode_b), .q(q0), .q_n(qn0));

  presc_dual_modulus #(.TOGGLE_STAGE(1'b0)) i_presc_dual_modulus_half (
    .clk(clk), .rst(rst), .mode_a(mode_a), .mode_b(mode_b), .q(q1), .q_n(qn1));

  // Behavioural reference: remaining clocks in the current half-period.
  int   left [2];
  logic rq [2];
  logic rlong [2];
  logic m_long;

  function automatic int hi_len(int v, logic lng);
    if (v == 0) return lng ? 6 : 5;
    return lng ? 3 : 2;
  endfunction

  function automatic int lo_len(int v);
    return (v == 0) ? 5 : 3;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    m_long = !(mode_a || mode_b);
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        rq[v] = 1'b0;
        left[v] = 1;
        rlong[v] = 1'b0;
      end else begin
        left[v] = left[v] - 1;
        if (left[v] == 0) begin
          rq[v] = !rq[v];
          if (rq[v]) begin
            rlong[v] = m_long;
            left[v] = hi_len(v, m_long);
          end else begin
            left[v] = lo_len(v);
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Run-length measurement on the main copy.
  int   run = 0;
  int   hi_run = 0;
  logic prev0 = 1'b0;
  logic per_long = 1'b0;
  bit   seen_rise = 1'b0;
  bit   seen_fall = 1'b0;

  always @(negedge clk) begin
    if (started && !done) begin
      string tag;
      if (rst) tag = "R7";
      else if (!(mode_a || mode_b) != rlong[0]) tag = "R5";
      else tag = rlong[0] ? "R3" : "R4";
      check(q0 === rq[0], tag, int'(q0), int'(rq[0]));
      check(qn0 === ~q0, "R6", int'(qn0), int'(~q0));
      check(q1 === rq[1], rst ? "R7" : "R8", int'(q1), int'(rq[1]));
      check(qn1 === !rq[1], "R8", int'(qn1), int'(!rq[1]));

      if (rst) begin
        run = 0; prev0 = 1'b0; seen_rise = 1'b0; seen_fall = 1'b0;
      end else if (q0 === prev0) begin
        run++;
      end else begin
        if (!q0) begin
          if (seen_rise)
            check(run == hi_len(0, rlong[0]), rlong[0] ? "R3" : "R4",
                  run, hi_len(0, rlong[0]));
          hi_run = run;
          per_long = rlong[0];
          seen_fall = 1'b1;
        end else begin
          if (seen_fall)
            check(hi_run + run == (per_long ? 11 : 10), per_long ? "R1" : "R2",
                  hi_run + run, per_long ? 11 : 10);
          seen_rise = 1'b1;
        end
        run = 1;
        prev0 = q0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;                              // R7 release, divide by 11 (R1)
    step(45);
    mode_a = 1'b1;                           // R2
    step(40);
    mode_a = 1'b0; mode_b = 1'b1;            // R2 via the other pin
    step(40);
    mode_a = 1'b1;
    step(30);
    mode_a = 1'b0; mode_b = 1'b0;            // back to R1
    step(30);
    for (int i = 0; i < 400; i++) begin      // R5: mid-period mode changes
      step(1);
      if ($urandom_range(0, 3) == 0) begin
        mode_a = 1'($urandom_range(0, 1));
        mode_b = 1'($urandom_range(0, 1));
      end
    end
    mode_a = 1'b1; mode_b = 1'b0;
    rst = 1'b1;                              // R7 mid-run reset
    step(2);
    rst = 1'b0;
    step(30);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule